// File: doc/BRIEF.md
# Command Transaction Sequencer

This block is a hardware master that carries out one command exchange with an embedded controller through a pair of byte-wide FIFOs. The block pushes bytes into a transmit FIFO and pops bytes from a receive FIFO. The caller supplies an opcode, an argument count N (0 to 7) and the argument bytes, then pulses `start`. The sequencer sends the opcode and then the N arguments. It takes one acknowledge byte from the controller, then collects M response bytes (0 to 7) into an eight-entry result buffer. Each wait for FIFO space or for incoming data is bounded. If a wait runs out, the sequencer reports a sticky timeout and abandons the exchange.

Out of reset the block runs a fixed startup routine on its own. It discards one byte waiting on the receive side and then queries the controller twice, with no arguments and two response bytes each time. The first query (opcode 0x0C) fetches the event status word and the second (opcode 0x11) fetches the external status word. Both words are assembled with the first received byte in the upper half. Once this routine finishes, `busy` falls and the block accepts commands.

Top module: `cts_seq`

## Requirements
- R1: From reset `busy` is high, `done` and `timeout_err` are low and nothing is pushed. The startup routine pops one receive byte and discards it. It then sends opcode 0x0C and, after that exchange completes, opcode 0x11. Neither startup exchange pulses `done`.
- R2: `event_word` holds the two response bytes of the 0x0C query and `ext_word` holds those of the 0x11 query. In both, the first byte received sits in bits 15:8 and the second in bits 7:0.
- R3: If no receive byte appears for the startup discard within POLL_LIMIT cycles, the routine moves on to the 0x0C query and does not set `timeout_err`.
- R4: A command puts exactly N+1 bytes on `tx_data`, in this order: `cmd_opcode` first, then argument k (k = 0..N-1) taken from `cmd_args[8k+7:8k]`.
- R5: The first byte popped after the last transmitted byte is the acknowledge byte. It appears on `ack_byte` and does not change the sequence.
- R6: The M response bytes after the acknowledge byte are written to `resp_bytes[8i+7:8i]` for i = 0..M-1, in arrival order. Entries at i >= M keep their previous value, and reset clears all entries to zero. `resp_word` equals {entry 0, entry 1}.
- R7: `tx_push` is high only while `tx_ready` is high, and `rx_pop` only while `rx_valid` is high. The two are never high together, and neither is high while `busy` is low.
- R8: `start` is taken only while `busy` is low. A pulse during an exchange has no effect and does not queue a later command.
- R9: A command that completes without error raises `done` for exactly one cycle, on the same edge where `busy` falls.
- R10: Each wait allows up to POLL_LIMIT cycles, and the byte is accepted if it arrives on the last of them. If POLL_LIMIT consecutive cycles pass with no transfer during a command, `timeout_err` rises and `busy` falls on the same edge, and `done` stays low.
- R11: `timeout_err` stays high until reset, even across later successful commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, taken only while idle |
| cmd_opcode | input | 8 | Opcode byte of the command |
| cmd_nargs | input | 3 | Number of argument bytes N |
| cmd_args | input | 64 | Argument bytes, argument k in bits 8k+7:8k |
| cmd_nresp | input | 3 | Number of response bytes M |
| tx_ready | input | 1 | Transmit FIFO is not full |
| tx_push | output | 1 | Pushes `tx_data` into the transmit FIFO this cycle |
| tx_data | output | 8 | Byte being transmitted |
| rx_valid | input | 1 | Receive FIFO is not empty |
| rx_data | input | 8 | Byte at the head of the receive FIFO |
| rx_pop | output | 1 | Takes `rx_data` and clears the not-empty indication |
| busy | output | 1 | Startup routine or command in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| timeout_err | output | 1 | Sticky wait-expiry error |
| ack_byte | output | 8 | Last acknowledge byte received |
| resp_bytes | output | 64 | Result buffer, entry i in bits 8i+7:8i |
| resp_word | output | 16 | Entries 0 and 1 joined, entry 0 upper |
| event_word | output | 16 | Event status word from startup |
| ext_word | output | 16 | External status word from startup |

## Verification
Every cycle, the assertions check the FIFO handshake discipline and the quiet idle state. They also check the single-cycle `done` pulse, the fact that the timeout error never clears itself, and that every wait ends no sooner and no later than its limit. Other properties need the bench's scenarios to show them. These are the byte order on the transmit side, which incoming byte is taken as the acknowledge, where each response lands in the buffer and which entries are left alone. The bench scenarios also cover the assembly of the startup words, the discard that times out harmlessly at startup, and the fact that a `start` during an exchange is dropped.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int BYTE_W    = 8;
  localparam int BUF_DEPTH = 8;
  localparam int IDX_W     = $clog2(BUF_DEPTH);
  localparam int FLAT_W    = BUF_DEPTH * BYTE_W;

  localparam logic [BYTE_W-1:0] OP_EVENT_Q  = 8'h0C;
  localparam logic [BYTE_W-1:0] OP_EXTERN_Q = 8'h11;

  typedef enum logic [2:0] {
    ST_FLUSH, ST_SEND, ST_ACK, ST_RESP, ST_IDLE
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_USER, PH_EVENT, PH_EXTERN
  } phase_t;

  // first byte received is the high half
  function automatic logic [2*BYTE_W-1:0] join_hi_lo(input logic [BYTE_W-1:0] hi,
                                                      input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [FLAT_W-1:0] v,
                                                   input logic [IDX_W-1:0] i);
    return v[int'(i)*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/cts_poll.sv
module cts_poll #(
  parameter int unsigned LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expire = waiting && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!waiting || expire) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cts_rbuf.sv
module cts_rbuf
  import cts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [FLAT_W-1:0] flat
);
  logic [BYTE_W-1:0] mem [BUF_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_flat
    assign flat[g*BYTE_W +: BYTE_W] = mem[g];
  end
endmodule

// File: rtl/cts_seq.sv
module cts_seq
  import cts_pkg::*;
#(
  parameter int unsigned POLL_LIMIT = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] cmd_opcode,
  input  logic [IDX_W-1:0]  cmd_nargs,
  input  logic [FLAT_W-1:0] cmd_args,
  input  logic [IDX_W-1:0]  cmd_nresp,
  input  logic              tx_ready,
  output logic              tx_push,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_pop,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic [BYTE_W-1:0] ack_byte,
  output logic [FLAT_W-1:0] resp_bytes,
  output logic [15:0]       resp_word,
  output logic [15:0]       event_word,
  output logic [15:0]       ext_word
);
  seq_state_t        st;
  phase_t            phase;
  logic [BYTE_W-1:0] op_q;
  logic [IDX_W-1:0]  nargs_q, nresp_q, idx;
  logic [FLAT_W-1:0] args_q;

  // named internal events
  logic step, waiting, poll_expire, abort, resp_take, xchg_end;
  logic [15:0] final_word;

  assign busy      = (st != ST_IDLE);
  assign tx_push   = (st == ST_SEND) && tx_ready;
  assign rx_pop    = (st == ST_FLUSH || st == ST_ACK || st == ST_RESP) && rx_valid;
  assign step      = tx_push || rx_pop;
  assign waiting   = busy && !step;
  assign abort     = poll_expire && (st != ST_FLUSH);
  assign resp_take = (st == ST_RESP) && rx_pop;
  assign xchg_end  = (resp_take && (idx == nresp_q - 1'b1))
                  || ((st == ST_ACK) && rx_pop && (nresp_q == '0));
  assign tx_data   = (idx == '0) ? op_q : pick_byte(args_q, idx - 1'b1);
  assign final_word = join_hi_lo(resp_bytes[BYTE_W-1:0], rx_data);
  assign resp_word  = join_hi_lo(resp_bytes[BYTE_W-1:0], resp_bytes[2*BYTE_W-1:BYTE_W]);

  cts_poll #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .waiting (waiting),
    .expire  (poll_expire)
  );

  cts_rbuf u_rbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (resp_take),
    .wr_idx  (idx),
    .wr_data (rx_data),
    .flat    (resp_bytes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_FLUSH;
      phase       <= PH_EVENT;
      op_q        <= OP_EVENT_Q;
      nargs_q     <= '0;
      nresp_q     <= IDX_W'(2);
      args_q      <= '0;
      idx         <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      ack_byte    <= '0;
      event_word  <= '0;
      ext_word    <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        st          <= ST_IDLE;
        phase       <= PH_USER;
        timeout_err <= 1'b1;
      end else if (xchg_end) begin
        unique case (phase)
          PH_EVENT: begin
            event_word <= final_word;
            op_q       <= OP_EXTERN_Q;
            phase      <= PH_EXTERN;
            st         <= ST_SEND;
            idx        <= '0;
          end
          PH_EXTERN: begin
            ext_word <= final_word;
            phase    <= PH_USER;
            st       <= ST_IDLE;
          end
          default: begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        endcase
        if (st == ST_ACK) ack_byte <= rx_data;
      end else begin
        unique case (st)
          ST_FLUSH: if (rx_pop || poll_expire) begin
            st  <= ST_SEND;
            idx <= '0;
          end
          ST_SEND: if (tx_push) begin
            if (idx == nargs_q) begin
              st  <= ST_ACK;
              idx <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          ST_ACK: if (rx_pop) begin
            ack_byte <= rx_data;
            st       <= ST_RESP;
            idx      <= '0;
          end
          ST_RESP: if (rx_pop) idx <= idx + 1'b1;
          default: if (start) begin
            op_q    <= cmd_opcode;
            nargs_q <= cmd_nargs;
            nresp_q <= cmd_nresp;
            args_q  <= cmd_args;
            phase   <= PH_USER;
            idx     <= '0;
            st      <= ST_SEND;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cts_seq_chk.sv
module cts_seq_chk #(
  parameter int unsigned POLL_LIMIT = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic timeout_err,
  input logic tx_ready,
  input logic tx_push,
  input logic rx_valid,
  input logic rx_pop,
  input logic poll_expire
);
  localparam int CW = $clog2(POLL_LIMIT + 1);

  // length of the current run of cycles with no transfer
  logic [CW-1:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (!busy || tx_push || rx_pop || poll_expire) run <= '0;
    else run <= run + 1'b1;
  end

  p_push_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> tx_ready);
  p_pop_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_valid);
  p_one_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_push && rx_pop));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tx_push && !rx_pop));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_poll_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run < CW'(POLL_LIMIT));
  p_expire_late_r10: assert property (@(posedge clk) disable iff (!rst_n)
    poll_expire |-> (run == CW'(POLL_LIMIT - 1)));
  p_err_drops_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> !busy);
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
endmodule

bind cts_seq cts_seq_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .timeout_err (timeout_err),
  .tx_ready    (tx_ready),
  .tx_push     (tx_push),
  .rx_valid    (rx_valid),
  .rx_pop      (rx_pop),
  .poll_expire (poll_expire)
);

// File: tb/sim_cts_seq.sv
`timescale 1ns/100ps
module sim_cts_seq;
  localparam int LIM = 10000;

  logic        clk = 1'b0;
  logic        rst_n, start;
  logic [7:0]  cmd_opcode;
  logic [2:0]  cmd_nargs, cmd_nresp;
  logic [63:0] cmd_args;
  logic        tx_ready = 1'b0, tx_push;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_pop, busy, done, timeout_err;
  logic [7:0]  ack_byte;
  logic [63:0] resp_bytes;
  logic [15:0] resp_word, event_word, ext_word;

  always #2.5 clk = ~clk;

  cts_seq #(.POLL_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_opcode(cmd_opcode),
    .cmd_nargs(cmd_nargs), .cmd_args(cmd_args), .cmd_nresp(cmd_nresp),
    .tx_ready(tx_ready), .tx_push(tx_push), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
    .busy(busy), .done(done), .timeout_err(timeout_err), .ack_byte(ack_byte),
    .resp_bytes(resp_bytes), .resp_word(resp_word),
    .event_word(event_word), .ext_word(ext_word)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [7:0] rxq [0:1023];
  logic [7:0] txlog [0:1023];
  int rx_head = 0, rx_tail = 0, tx_cnt = 0, done_cnt = 0;
  bit tx_block = 0, rx_block = 0;
  int stall_pct = 0;
  logic [7:0] exp_buf [8];

  // FIFO model: drive half a cycle-tick after the falling edge, then record transfers
  always begin
    @(negedge clk);
    #0.5;
    tx_ready = !tx_block && ($urandom_range(0, 99) >= stall_pct);
    rx_valid = rst_n && (rx_head != rx_tail) && !rx_block
               && ($urandom_range(0, 99) >= stall_pct);
    rx_data  = rx_valid ? rxq[rx_head] : 8'h00;
    #1;
    if (rst_n) begin
      if (tx_push) begin txlog[tx_cnt] = tx_data; tx_cnt++; end
      if (rx_pop) rx_head++;
      if (done) done_cnt++;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input logic [7:0] first, input logic [7:0] second);
    return 16'(first) * 16'd256 + 16'(second);
  endfunction

  function automatic logic [7:0] byte_at(input logic [63:0] v, input int k);
    return 8'((v >> (8 * k)) & 64'hFF);
  endfunction

  task automatic push_rx(input logic [7:0] b);
    rxq[rx_tail] = b;
    rx_tail++;
  endtask

  task automatic wait_idle(input int limit, output int cycles);
    cycles = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk); #2;
      cycles++;
      if (!busy) break;
    end
  endtask

  task automatic check_buf(input string req);
    for (int k = 0; k < 8; k++)
      chk(req, "buffer entry", 32'(byte_at(resp_bytes, k)), 32'(exp_buf[k]));
    chk(req, "resp_word", 32'(resp_word), 32'(word_of(exp_buf[0], exp_buf[1])));
  endtask

  task automatic pulse_start(input logic [7:0] op, input int n, input int m,
                             input logic [63:0] args);
    @(negedge clk);
    start = 1'b1; cmd_opcode = op; cmd_nargs = 3'(n); cmd_nresp = 3'(m); cmd_args = args;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] op, input int n, input int m);
    logic [63:0] args;
    logic [7:0] ack;
    int base, d0, cycles;
    bit err0;
    args = {$urandom(), $urandom()};
    ack  = 8'($urandom());
    base = tx_cnt; d0 = done_cnt; err0 = timeout_err;
    push_rx(ack);
    for (int i = 0; i < m; i++) begin
      exp_buf[i] = 8'($urandom());
      push_rx(exp_buf[i]);
    end
    pulse_start(op, n, m, args);
    wait_idle(3000, cycles);
    chk("R4", "byte count", 32'(tx_cnt - base), 32'(n + 1));
    chk("R4", "opcode first", 32'(txlog[base]), 32'(op));
    for (int k = 0; k < n; k++)
      chk("R4", "argument order", 32'(txlog[base + 1 + k]), 32'(byte_at(args, k)));
    chk("R5", "ack latched", 32'(ack_byte), 32'(ack));
    check_buf("R6");
    chk("R9", "single done", 32'(done_cnt - d0), 32'd1);
    chk("R11", "error unchanged", 32'(timeout_err), 32'(err0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int cycles, base, d0;
    void'($urandom(32'h5EED0042));
    rst_n = 1'b0; start = 1'b0; cmd_opcode = '0; cmd_nargs = '0; cmd_nresp = '0; cmd_args = '0;
    for (int k = 0; k < 8; k++) exp_buf[k] = 8'h00;
    // startup replies: discard, ack, event word, ack, external word
    push_rx(8'hEE); push_rx(8'hA1); push_rx(8'h12); push_rx(8'h34);
    push_rx(8'hA2); push_rx(8'h56); push_rx(8'h78);
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "busy in reset", 32'(busy), 32'd1);
    chk("R1", "done in reset", 32'(done), 32'd0);
    chk("R1", "error in reset", 32'(timeout_err), 32'd0);
    chk("R1", "no push in reset", 32'(tx_push), 32'd0);
    rst_n = 1'b1;
    wait_idle(300, cycles);
    chk("R1", "startup byte count", 32'(tx_cnt), 32'd2);
    chk("R1", "event query opcode", 32'(txlog[0]), 32'h0C);
    chk("R1", "external query opcode", 32'(txlog[1]), 32'h11);
    chk("R1", "all replies consumed", 32'(rx_head), 32'd7);
    chk("R1", "no done at startup", 32'(done_cnt), 32'd0);
    chk("R2", "event word", 32'(event_word), 32'h1234);
    chk("R2", "external word", 32'(ext_word), 32'h5678);
    chk("R5", "startup ack", 32'(ack_byte), 32'hA2);
    exp_buf[0] = 8'h56; exp_buf[1] = 8'h78;
    check_buf("R6");

    // directed corners, then random commands with stalls
    run_cmd(8'h3C, 0, 0);
    run_cmd(8'hC5, 7, 7);
    stall_pct = 35;
    for (int t = 0; t < 16; t++)
      run_cmd(8'($urandom()), int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
    stall_pct = 0;

    // R8: start during an exchange is dropped
    base = tx_cnt; d0 = done_cnt;
    push_rx(8'h4B); exp_buf[0] = 8'hD7; push_rx(8'hD7);
    tx_block = 1;
    pulse_start(8'h5A, 1, 1, 64'h99);
    repeat (3) @(negedge clk);
    #2;
    chk("R8", "busy before second start", 32'(busy), 32'd1);
    pulse_start(8'h77, 3, 0, 64'h112233);
    tx_block = 0;
    wait_idle(200, cycles);
    repeat (20) @(negedge clk);
    #2;
    chk("R8", "only first command sent", 32'(tx_cnt - base), 32'd2);
    chk("R8", "first opcode kept", 32'(txlog[base]), 32'h5A);
    chk("R8", "nothing queued", 32'(busy), 32'd0);
    chk("R8", "one done", 32'(done_cnt - d0), 32'd1);
    check_buf("R8");

    // R10: space appears shortly before the limit -> no error
    base = tx_cnt; d0 = done_cnt;
    push_rx(8'h61);
    tx_block = 1;
    pulse_start(8'h2D, 0, 0, 64'h0);
    repeat (LIM - 6) @(negedge clk);
    tx_block = 0;
    wait_idle(200, cycles);
    chk("R10", "late space accepted", 32'(tx_cnt - base), 32'd1);
    chk("R10", "no error near limit", 32'(timeout_err), 32'd0);
    chk("R10", "done near limit", 32'(done_cnt - d0), 32'd1);

    // R10: response wait expires
    d0 = done_cnt;
    push_rx(8'hC3); push_rx(8'h99);
    exp_buf[0] = 8'h99;
    pulse_start(8'h40, 0, 3, 64'h0);
    wait_idle(LIM + 100, cycles);
    chk("R10", "error on receive expiry", 32'(timeout_err), 32'd1);
    chk("R10", "idle after expiry", 32'(busy), 32'd0);
    chk("R10", "no done on expiry", 32'(done_cnt - d0), 32'd0);
    chk("R10", "expiry not early", 32'(cycles >= LIM - 2), 32'd1);
    chk("R10", "expiry not late", 32'(cycles <= LIM + 8), 32'd1);
    check_buf("R6");

    // R11: sticky across a good command
    run_cmd(8'h0F, 2, 2);
    chk("R11", "still flagged", 32'(timeout_err), 32'd1);

    // R10: transmit wait expires
    base = tx_cnt; d0 = done_cnt;
    tx_block = 1;
    pulse_start(8'h81, 2, 0, 64'h0);
    wait_idle(LIM + 100, cycles);
    tx_block = 0;
    chk("R10", "no push on transmit expiry", 32'(tx_cnt - base), 32'd0);
    chk("R10", "no done on transmit expiry", 32'(done_cnt - d0), 32'd0);
    chk("R10", "idle after transmit expiry", 32'(busy), 32'd0);

    // R3: startup discard finds nothing
    @(negedge clk);
    rst_n = 1'b0;
    rx_head = rx_tail;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    base = tx_cnt;
    for (int i = 0; i < LIM + 200; i++) begin
      @(negedge clk); #2;
      if (tx_cnt != base) break;
    end
    chk("R3", "event query after empty discard", 32'(txlog[base]), 32'h0C);
    push_rx(8'hB1); push_rx(8'hAB); push_rx(8'hCD);
    push_rx(8'hB2); push_rx(8'h01); push_rx(8'h02);
    wait_idle(300, cycles);
    chk("R3", "no error from empty discard", 32'(timeout_err), 32'd0);
    chk("R2", "event word after empty discard", 32'(event_word), 32'hABCD);
    chk("R2", "external word after empty discard", 32'(ext_word), 32'h0102);
    chk("R1", "second external opcode", 32'(txlog[base + 1]), 32'h11);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule